// File: doc/BRIEF.md
# Processor Clock Mode Controller

This block picks the clock that drives a small processor core. Software controls it through one 8-bit control word. In normal mode the core runs from the main oscillator, divided by a power of two that software selects. In subclock mode the core runs from a slow clock. A reset-time option input decides whether that slow clock is the external low-speed crystal or the internal low-speed oscillator. Once the core is running on the slow clock, software may turn the main oscillator off. The whole system then lives on the slow clock.

The switch between the divided main clock and the subclock has no glitches. Each side has its own enable flop chain, clocked on the falling edge of that side's clock. The old clock is gated off before the new one is gated on. A read-only status bit reports which clock is really driving the core, so software polls it rather than counting delays. The block also enforces the write rules:

- A write that flips the subclock request must not also move the divider.
- Entry to subclock mode needs a "divided main clock is more than four times the subclock" indication from outside.
- The main oscillator can only be stopped while the core runs on the subclock.
- Subclock mode cannot be left while the main oscillator is stopped.

Refused transitions set a sticky error flag.

Control word layout: bits [2:0] divider code, bit 3 subclock request, bit 4 main oscillator stop, bit 5 sticky error (write 1 to clear), bit 6 clock status (read-only, 1 = core on subclock), bit 7 reads 0.

Top module: `clkmode_ctrl`

## Requirements
- R1: After reset the control word reads 0x00, `main_osc_en_o` is 1 and the core clock is the undivided main clock.
- R2: Divider codes 0 to 5 in bits [2:0] make the core clock period 1, 2, 4, 8, 16 or 32 main clock periods. A write of code 6 or 7 leaves the stored divider code unchanged.
- R3: A write that changes bit 3 from 0 to 1 is accepted only while `ratio_ok_i` is 1. Otherwise bit 3 stays 0, bit 5 becomes 1 and the core stays on the main clock.
- R4: A write that changes bit 3 and also carries a different divider code keeps the old divider code. Bit 3 still follows its own rules.
- R5: Status bit 6 becomes 1 only after the core clock has the subclock period. It returns to 0 only after the core clock is back on the divided main clock. It is still 0 on the cycle right after an entry write.
- R6: Writing bit 4 as 1 takes effect only when status bit 6 is 1, bit 3 is 1 and the write keeps bit 3 at 1. Otherwise it is ignored. Writing bit 4 as 0 always clears it. `main_osc_en_o` is the inverse of bit 4.
- R7: A write that changes bit 3 from 1 to 0 while bit 4 is 1 is refused. Bit 3 stays 1 and bit 5 becomes 1.
- R8: Writing 1 to bit 5 clears the error flag, unless the same write is refused, in which case the flag stays 1.
- R9: `sub_src_opt_i` is captured on the first register clock after reset. A value of 0 selects `xt_clk_i` as the subclock and 1 selects `lso_clk_i`.
- R10: The core clock never shows a high or low phase shorter than half the fastest source period, and the two clock enables are never on together.
- R11: Asserting reset while in subclock mode, even with the main oscillator stopped, returns the block to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| reg_clk_i | input | 1 | Always-running register clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 8 | Control word write value |
| rd_data_o | output | 8 | Control word read value including status |
| ratio_ok_i | input | 1 | Divided main clock exceeds four times the subclock |
| sub_src_opt_i | input | 1 | Reset-time subclock source option |
| main_clk_i | input | 1 | Main oscillator clock |
| xt_clk_i | input | 1 | External low-speed crystal clock |
| lso_clk_i | input | 1 | Internal low-speed oscillator clock |
| main_osc_en_o | output | 1 | Main oscillator enable |
| cpu_clk_o | output | 1 | Core clock |

## Verification
A wrong register state shows up on `rd_data_o` on the next register clock. The bench's behavioural model is compared against every field on every cycle, so a mis-applied write rule is caught one cycle after the offending write. A wrong divider tap or a wrong subclock source shows up as a wrong core clock period, measured a few hundred nanoseconds after each change. A status bit that moves too early is caught by measuring the period right after status flips, and a runt pulse is caught by an edge-to-edge width monitor.

// File: rtl/ckm_pkg.sv
`timescale 1ns/1ps
package ckm_pkg;
   localparam int REG_W    = 8;
   localparam int DIV_W    = 3;
   localparam int B_SUBREQ = 3;
   localparam int B_MSTOP  = 4;
   localparam int B_ERR    = 5;
   localparam int B_STAT   = 6;

   typedef struct packed {
      logic             spare;
      logic             stat;
      logic             err;
      logic             mstop;
      logic             subreq;
      logic [DIV_W-1:0] div;
   } ctl_word_t;
endpackage

// File: rtl/ckm_sync.sv
`timescale 1ns/1ps
module ckm_sync #(
   parameter int STAGES   = 2,
   parameter bit NEG_EDGE = 1'b0,
   parameter bit RST_VAL  = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("ckm_sync: STAGES must be at least 2");
   end

   if (NEG_EDGE) begin : g_fall
      always_ff @(negedge clk_i or negedge rst_ni) begin
         if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
         else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
   end else begin : g_rise
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
         else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ckm_div.sv
`timescale 1ns/1ps
module ckm_div #(
   parameter int DIV_W       = 3,
   parameter int DIV_MAX     = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic             main_clk_i,
   input  logic             rst_ni,
   input  logic [DIV_W-1:0] code_i,
   output logic             mdiv_clk_o
);
   localparam int CNT_W = (DIV_MAX < 1) ? 1 : DIV_MAX;
   localparam int NTAPS = DIV_MAX + 1;

   logic [CNT_W-1:0] cnt_q;
   logic [DIV_W-1:0] code_s;
   logic [DIV_W-1:0] code_q;
   logic [CNT_W:0]   taps;

   for (genvar b = 0; b < DIV_W; b++) begin : g_code_sync
      ckm_sync #(.STAGES(SYNC_STAGES), .NEG_EDGE(1'b0), .RST_VAL(1'b0)) u_bit (
         .clk_i (main_clk_i),
         .rst_ni(rst_ni),
         .d_i   (code_i[b]),
         .q_o   (code_s[b])
      );
   end

   always_ff @(posedge main_clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else         cnt_q <= cnt_q + CNT_W'(1);
   end

   // taps are all low here, so the tap change is clean
   always_ff @(negedge main_clk_i or negedge rst_ni) begin
      if (!rst_ni) code_q <= '0;
      else if (cnt_q == '0 && code_s <= DIV_W'(DIV_MAX)) code_q <= code_s;
   end

   assign taps = {cnt_q, main_clk_i};

   always_comb begin
      mdiv_clk_o = 1'b0;
      for (int i = 0; i < NTAPS; i++) begin
         if (code_q == DIV_W'(i)) mdiv_clk_o = taps[i];
      end
   end

   AST_TAP_CODE_RANGE: assert property (@(negedge main_clk_i) disable iff (!rst_ni)
      code_q <= DIV_W'(DIV_MAX)); // R2
endmodule

// File: rtl/ckm_gfmux.sv
`timescale 1ns/1ps
module ckm_gfmux #(
   parameter int SYNC_STAGES = 2
) (
   input  logic rst_ni,
   input  logic sel_sub_i,
   input  logic mdiv_clk_i,
   input  logic sub_clk_i,
   output logic cpu_clk_o,
   output logic m_en_o,
   output logic s_en_o
);
   logic m_en;
   logic s_en;

   ckm_sync #(.STAGES(SYNC_STAGES), .NEG_EDGE(1'b1), .RST_VAL(1'b1)) u_main_en (
      .clk_i (mdiv_clk_i),
      .rst_ni(rst_ni),
      .d_i   (~sel_sub_i & ~s_en),
      .q_o   (m_en)
   );

   ckm_sync #(.STAGES(SYNC_STAGES), .NEG_EDGE(1'b1), .RST_VAL(1'b0)) u_sub_en (
      .clk_i (sub_clk_i),
      .rst_ni(rst_ni),
      .d_i   (sel_sub_i & ~m_en),
      .q_o   (s_en)
   );

   assign cpu_clk_o = (mdiv_clk_i & m_en) | (sub_clk_i & s_en);
   assign m_en_o    = m_en;
   assign s_en_o    = s_en;

   always_comb begin
      if (rst_ni === 1'b1) begin
         AST_CLK_EXCLUSIVE: assert (!(m_en && s_en)); // R10
      end
   end
endmodule

// File: rtl/ckm_regs.sv
`timescale 1ns/1ps
module ckm_regs
   import ckm_pkg::*;
#(
   parameter int DIV_MAX = 5
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_en_i,
   input  logic [REG_W-1:0] wr_data_i,
   input  logic             ratio_ok_i,
   input  logic             m_en_s_i,
   input  logic             s_en_s_i,
   output logic [REG_W-1:0] rd_data_o,
   output logic [DIV_W-1:0] div_o,
   output logic             sub_req_o,
   output logic             main_stop_o
);
   logic [DIV_W-1:0] div_q, div_d, w_div;
   logic sub_q, sub_d, stop_q, stop_d, err_q, err_d, status_q;
   logic w_sub, w_stop, w_clr, toggle, refuse;
   ctl_word_t rd_w;

   assign w_div  = wr_data_i[DIV_W-1:0];
   assign w_sub  = wr_data_i[B_SUBREQ];
   assign w_stop = wr_data_i[B_MSTOP];
   assign w_clr  = wr_data_i[B_ERR];
   assign toggle = w_sub ^ sub_q;

   always_comb begin
      div_d  = div_q;
      sub_d  = sub_q;
      stop_d = stop_q;
      err_d  = err_q;
      refuse = 1'b0;
      if (wr_en_i) begin
         if (w_div <= DIV_W'(DIV_MAX) && !(toggle && w_div != div_q)) div_d = w_div;
         if (toggle && w_sub) begin
            if (ratio_ok_i) sub_d = 1'b1;
            else            refuse = 1'b1;
         end
         if (toggle && !w_sub) begin
            if (stop_q) refuse = 1'b1;
            else        sub_d = 1'b0;
         end
         if (!w_stop)                          stop_d = 1'b0;
         else if (status_q && sub_q && w_sub) stop_d = 1'b1;
         if (refuse)     err_d = 1'b1;
         else if (w_clr) err_d = 1'b0;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         div_q    <= '0;
         sub_q    <= 1'b0;
         stop_q   <= 1'b0;
         err_q    <= 1'b0;
         status_q <= 1'b0;
      end else begin
         div_q  <= div_d;
         sub_q  <= sub_d;
         stop_q <= stop_d;
         err_q  <= err_d;
         if (s_en_s_i && !m_en_s_i)      status_q <= 1'b1;
         else if (m_en_s_i && !s_en_s_i) status_q <= 1'b0;
      end
   end

   always_comb begin
      rd_w        = '0;
      rd_w.div    = div_q;
      rd_w.subreq = sub_q;
      rd_w.mstop  = stop_q;
      rd_w.err    = err_q;
      rd_w.stat   = status_q;
   end

   assign rd_data_o   = rd_w;
   assign div_o       = div_q;
   assign sub_req_o   = sub_q;
   assign main_stop_o = stop_q;

   AST_DIV_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      div_q <= DIV_W'(DIV_MAX)); // R2
   AST_ENTRY_RATIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sub_q) |-> $past(ratio_ok_i)); // R3
   AST_COMBINED_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && (w_sub != sub_q) && (w_div != div_q)) |=> $stable(div_q)); // R4
   AST_STATUS_AFTER_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(status_q) |-> $past(s_en_s_i)); // R5
   AST_STOP_ON_SUB: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stop_q |-> (status_q && sub_q)); // R6
   AST_EXIT_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(sub_q) |-> !$past(stop_q)); // R7
endmodule

// File: rtl/clkmode_ctrl.sv
`timescale 1ns/1ps
module clkmode_ctrl
   import ckm_pkg::*;
#(
   parameter int DIV_MAX     = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic             reg_clk_i,
   input  logic             rst_ni,
   input  logic             wr_en_i,
   input  logic [REG_W-1:0] wr_data_i,
   output logic [REG_W-1:0] rd_data_o,
   input  logic             ratio_ok_i,
   input  logic             sub_src_opt_i,
   input  logic             main_clk_i,
   input  logic             xt_clk_i,
   input  logic             lso_clk_i,
   output logic             main_osc_en_o,
   output logic             cpu_clk_o
);
   if (DIV_MAX < 1 || DIV_MAX >= (1 << DIV_W)) begin : g_bad_div
      $error("clkmode_ctrl: DIV_MAX must fit the divider field");
   end

   logic             opt_q, opt_done_q;
   logic             sub_clk;
   logic [DIV_W-1:0] div_code;
   logic             sub_req, main_stop;
   logic             mdiv_clk;
   logic             m_en, s_en, m_en_s, s_en_s;

   always_ff @(posedge reg_clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         opt_q      <= 1'b0;
         opt_done_q <= 1'b0;
      end else if (!opt_done_q) begin
         opt_q      <= sub_src_opt_i;
         opt_done_q <= 1'b1;
      end
   end

   assign sub_clk = opt_q ? lso_clk_i : xt_clk_i;

   ckm_regs #(.DIV_MAX(DIV_MAX)) u_regs (
      .clk_i      (reg_clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (wr_en_i),
      .wr_data_i  (wr_data_i),
      .ratio_ok_i (ratio_ok_i),
      .m_en_s_i   (m_en_s),
      .s_en_s_i   (s_en_s),
      .rd_data_o  (rd_data_o),
      .div_o      (div_code),
      .sub_req_o  (sub_req),
      .main_stop_o(main_stop)
   );

   ckm_div #(.DIV_W(DIV_W), .DIV_MAX(DIV_MAX), .SYNC_STAGES(SYNC_STAGES)) u_div (
      .main_clk_i(main_clk_i),
      .rst_ni    (rst_ni),
      .code_i    (div_code),
      .mdiv_clk_o(mdiv_clk)
   );

   ckm_gfmux #(.SYNC_STAGES(SYNC_STAGES)) u_mux (
      .rst_ni    (rst_ni),
      .sel_sub_i (sub_req),
      .mdiv_clk_i(mdiv_clk),
      .sub_clk_i (sub_clk),
      .cpu_clk_o (cpu_clk_o),
      .m_en_o    (m_en),
      .s_en_o    (s_en)
   );

   ckm_sync #(.STAGES(SYNC_STAGES), .NEG_EDGE(1'b0), .RST_VAL(1'b1)) u_m_stat (
      .clk_i(reg_clk_i), .rst_ni(rst_ni), .d_i(m_en), .q_o(m_en_s)
   );
   ckm_sync #(.STAGES(SYNC_STAGES), .NEG_EDGE(1'b0), .RST_VAL(1'b0)) u_s_stat (
      .clk_i(reg_clk_i), .rst_ni(rst_ni), .d_i(s_en), .q_o(s_en_s)
   );

   assign main_osc_en_o = ~main_stop;

   AST_OSC_FOLLOWS_STOP: assert property (@(posedge reg_clk_i) disable iff (!rst_ni)
      !main_osc_en_o |-> rd_data_o[B_STAT]); // R6
   AST_OPT_STABLE: assert property (@(posedge reg_clk_i) disable iff (!rst_ni)
      $past(opt_done_q) |-> $stable(opt_q)); // R9
endmodule

// File: tb/clkmode_ctrl_test.sv
`timescale 1ns/1ps
module clkmode_ctrl_test;
   localparam int CLK_PERIOD      = 10;
   localparam int MAIN_HALF       = 4;
   localparam int XT_HALF         = 100;
   localparam int LSO_HALF        = 65;
   localparam int WATCHDOG_CYCLES = 150000;

   logic       reg_clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       ratio_ok = 1'b1, sub_opt = 1'b0;
   logic       main_clk = 1'b0, xt_clk = 1'b0, lso_clk = 1'b0;
   logic       main_osc_en, cpu_clk;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) reg_clk = ~reg_clk;
   always #(XT_HALF) xt_clk = ~xt_clk;
   always #(LSO_HALF) lso_clk = ~lso_clk;
   always begin
      #(MAIN_HALF);
      if (main_osc_en === 1'b1) main_clk = ~main_clk;
   end

   clkmode_ctrl uut (
      .reg_clk_i    (reg_clk),
      .rst_ni       (rst_n),
      .wr_en_i      (wr_en),
      .wr_data_i    (wr_data),
      .rd_data_o    (rd_data),
      .ratio_ok_i   (ratio_ok),
      .sub_src_opt_i(sub_opt),
      .main_clk_i   (main_clk),
      .xt_clk_i     (xt_clk),
      .lso_clk_i    (lso_clk),
      .main_osc_en_o(main_osc_en),
      .cpu_clk_o    (cpu_clk)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   // behavioural reference model of the control word
   int   m_div;
   bit   m_sub, m_stop, m_err, m_refuse, m_tog, seen_stat;
   bit   model_on = 1'b0;
   logic [7:0] exp_word;

   always @(posedge reg_clk) begin
      if (rst_n !== 1'b1) begin
         m_div = 0; m_sub = 0; m_stop = 0; m_err = 0;
      end else if (wr_en) begin
         seen_stat = rd_data[6];
         m_tog = (wr_data[3] != m_sub);
         m_refuse = 0;
         if (int'(wr_data[2:0]) <= 5 && !(m_tog && int'(wr_data[2:0]) != m_div))
            m_div = int'(wr_data[2:0]);
         if (m_tog && wr_data[3]) begin
            if (ratio_ok) m_sub = 1; else m_refuse = 1;
         end else if (m_tog && !wr_data[3]) begin
            if (m_stop) m_refuse = 1; else m_sub = 0;
         end
         if (!wr_data[4]) m_stop = 0;
         else if (seen_stat && !m_tog && wr_data[3]) m_stop = 1;
         if (m_refuse) m_err = 1;
         else if (wr_data[5]) m_err = 0;
      end
   end

   always @(negedge reg_clk) begin
      if (model_on && rst_n === 1'b1) begin
         exp_word = {2'b00, m_err, m_stop, m_sub, 3'(m_div)};
         check((rd_data & 8'hBF) === exp_word, "R2/R3/R4/R6/R7/R8 model compare",
               int'(rd_data & 8'hBF), int'(exp_word));
         check(main_osc_en === !m_stop, "R6 oscillator enable", int'(main_osc_en), int'(!m_stop));
      end
   end

   // runt pulse monitor
   realtime last_edge = 0.0;
   bit      mon_armed = 1'b0;
   int      runts = 0;
   always @(cpu_clk) begin
      if (rst_n !== 1'b1) mon_armed = 1'b0;
      else begin
         if (mon_armed && ($realtime - last_edge) < 3.9) runts++;
         mon_armed = 1'b1;
         last_edge = $realtime;
      end
   end

   task automatic write_word(input logic [7:0] d);
      @(negedge reg_clk);
      wr_en = 1'b1; wr_data = d;
      @(negedge reg_clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge reg_clk);
   endtask

   task automatic check_period(input int exp_ns, input string tag);
      realtime t0;
      int p;
      @(posedge cpu_clk);
      @(posedge cpu_clk);
      t0 = $realtime;
      @(posedge cpu_clk);
      p = int'($realtime - t0);
      check(p == exp_ns, tag, p, exp_ns);
      @(negedge reg_clk);
   endtask

   task automatic wait_status(input bit val, input string tag);
      int n = 0;
      while (rd_data[6] !== val && n < 1000) begin
         @(negedge reg_clk);
         n++;
      end
      check(rd_data[6] === val, tag, int'(rd_data[6]), int'(val));
   endtask

   task automatic do_reset(input bit opt);
      @(negedge reg_clk);
      rst_n = 1'b0; sub_opt = opt;
      idle(5);
      rst_n = 1'b1;
      @(negedge reg_clk);
   endtask

   initial begin
      repeat (WATCHDOG_CYCLES) @(posedge reg_clk);
      errors++;
      $display("FAIL watchdog R1-all: actual hang expected completion");
      summary();
      $finish;
   end

   initial begin
      do_reset(1'b0);
      model_on = 1'b1;
      // R1 reset state
      check(rd_data === 8'h00, "R1 reset word", int'(rd_data), 0);
      check(main_osc_en === 1'b1, "R1 oscillator on", int'(main_osc_en), 1);
      check_period(2*MAIN_HALF, "R1 undivided main clock");

      // R2 divider codes
      for (int k = 1; k <= 5; k++) begin
         write_word(8'(k));
         idle(60);
         check_period((2*MAIN_HALF) << k, "R2 divided period");
      end
      write_word(8'h06);
      check(rd_data[2:0] === 3'd5, "R2 reserved code 6 ignored", int'(rd_data[2:0]), 5);
      write_word(8'h07);
      check(rd_data[2:0] === 3'd5, "R2 reserved code 7 ignored", int'(rd_data[2:0]), 5);
      idle(40);
      check_period((2*MAIN_HALF) << 5, "R2 period kept after reserved code");
      write_word(8'h00);
      idle(60);

      // R3 entry refused without ratio
      ratio_ok = 1'b0;
      write_word(8'h08);
      check((rd_data & 8'hBF) === 8'h20, "R3 refused entry", int'(rd_data), 8'h20);
      idle(60);
      check_period(2*MAIN_HALF, "R3 still on main clock");
      // R8 clear error
      write_word(8'h20);
      check(rd_data[5] === 1'b0, "R8 error cleared", int'(rd_data[5]), 0);

      // R4 combined write keeps divider
      ratio_ok = 1'b1;
      write_word(8'h0B);
      check((rd_data & 8'hBF) === 8'h08, "R4 divider kept on toggle", int'(rd_data), 8'h08);
      check(rd_data[6] === 1'b0, "R5 status not yet set", int'(rd_data[6]), 0);
      // R6 stop ignored while status still on main
      write_word(8'h18);
      check(rd_data[4] === 1'b0, "R6 stop ignored before switch", int'(rd_data[4]), 0);
      wait_status(1'b1, "R5 status reaches subclock");
      check_period(2*XT_HALF, "R5 R9 crystal subclock period");

      // R6 stop accepted on subclock
      write_word(8'h18);
      check(main_osc_en === 1'b0, "R6 oscillator stopped", int'(main_osc_en), 0);
      check_period(2*XT_HALF, "R6 running on subclock with main stopped");

      // R7 exit refused while stopped
      write_word(8'h10);
      check((rd_data & 8'hBF) === 8'h38, "R7 exit refused", int'(rd_data & 8'hBF), 8'h38);
      // R8 refusal wins over clear; stop cleared by same write
      write_word(8'h20);
      check((rd_data & 8'hBF) === 8'h28, "R8 refusal keeps error", int'(rd_data & 8'hBF), 8'h28);
      check(main_osc_en === 1'b1, "R6 oscillator restarted", int'(main_osc_en), 1);
      idle(20);
      write_word(8'h20);
      check((rd_data & 8'hBF) === 8'h00, "R7 exit accepted after restart", int'(rd_data & 8'hBF), 0);
      wait_status(1'b0, "R5 status back on main");
      check_period(2*MAIN_HALF, "R5 main clock after exit");

      // R9 internal low-speed source, then R11 reset from subclock
      do_reset(1'b1);
      write_word(8'h08);
      wait_status(1'b1, "R9 status on internal source");
      check_period(2*LSO_HALF, "R9 internal low-speed period");
      write_word(8'h18);
      check(main_osc_en === 1'b0, "R11 setup oscillator stopped", int'(main_osc_en), 0);
      do_reset(1'b0);
      check(rd_data === 8'h00, "R11 reset word from subclock", int'(rd_data), 0);
      check(main_osc_en === 1'b1, "R11 oscillator on after reset", int'(main_osc_en), 1);
      check_period(2*MAIN_HALF, "R11 main clock after reset");

      // R10 glitch-free switching
      check(runts == 0, "R10 no runt pulses", runts, 0);

      summary();
      $finish;
   end
endmodule